// File: doc/BRIEF.md
# I2S Stereo Audio Port with Sample FIFOs

This peripheral moves 16-bit stereo audio between an APB host and an I2S codec. Software pushes packed sample words into an eight-entry transmit queue and pops captured words from an eight-entry receive queue. Each word carries the left sample in bits [31:16] and the right sample in bits [15:0]. The block drives the bit clock, the word-select line and serial data out, and it samples serial data in. Water-level alerts and error flags let software keep the queues from running dry or overflowing. An interrupt line combines the two alerts under separate enables. A test mode takes over the output pins from a software register and exposes the input pin.

The serial engine is a state machine with three states. S_IDLE holds the pins quiet: bit clock low, word select high, data low. When either direction is enabled, the engine takes S_IDLE to S_LEFT at the first falling bit-clock edge and pops the first transmit word. S_LEFT goes to S_RIGHT at the end of the left slot. S_RIGHT goes back to S_LEFT at the end of the right slot; on that transition the engine pushes the received word and pops the next transmit word. Clearing both enables returns the engine to S_IDLE from either slot state. The bit clock runs at half the APB clock.

Top module: `i2s_apb_audio`

## Requirements
- R1: After reset the register map reads: control 0x00002200 (both water levels 2), divide 0x080, status 0x15, error 0. The pins are bit clock 0, word select 1, data out 0, interrupt 0 and codec reset 0.
- R2: With transmit (control bit 0) and receive (control bit 2) enabled and data out looped to data in, the receive queue returns the transmit words unchanged and in order. Receive data is at offset 0x014 and transmit data at 0x010.
- R3: Word select falls when a left slot starts and rises when a right slot starts. A slot's 16 bits go out MSB first on bit clocks 1 to 16 after the word-select edge. Data out is 0 on bit clock 0 and after bit 16.
- R4: Status bit 0 (transmit alert) is 1 when the transmit free space exceeds the transmit level (control [10:8]). Status bit 1 (receive alert) is 1 when the receive free space is below the receive level (control [14:12]).
- R5: Status bits 2/3 flag transmit empty/full and bits 4/5 flag receive empty/full. A full queue accepts no further words.
- R6: A write to offset 0x010 while the transmit queue is full drops the word and sets error bit 0. Writing 1 to a bit of the error register (offset 0x008) clears that bit, and writing 0 leaves it alone.
- R7: When a left slot starts with transmit enabled and the transmit queue empty, error bit 0 is set and the frame goes out as zeros.
- R8: A received word that arrives with the receive queue full is dropped and sets error bit 1.
- R9: The interrupt is (transmit alert AND control bit 1) OR (receive alert AND control bit 3).
- R10: While control bit 16 is 1, both queues are held empty and writes of transmit data are ignored.
- R11: The codec reset pin follows control bit 17.
- R12: While bit 0 at offset 0x300 is 1, bits 0..3 of offset 0x308 drive data out, bit clock, word select and interrupt. Offset 0x304 bit 0 reads the data-in pin.
- R13: Each slot lasts max(divide, 17) bit clocks, so one frame is 4*max(divide,17) APB clock cycles. The divide register is at offset 0x00C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| i2s_sck | output | 1 | Bit clock |
| i2s_ws | output | 1 | Word select, low for left |
| i2s_sdo | output | 1 | Serial data out |
| i2s_sdi | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |
| codec_reset | output | 1 | Codec reset pin |

## Verification
The bench loops serial data back and pushes eight words with distinct MSB and LSB patterns through the link. A word-select or bit-order error would corrupt the words it reads back, and so would an off-by-one in the slot position. An independent pin monitor checks that each left sample appears MSB first one bit clock after word select falls. The bench drains the transmit queue while the link runs, to catch a design that repeats stale data instead of sending zeros and raising underrun. It then lets the receive queue overflow, to catch a design that overwrites stored words. The bench also sets a divide value below the minimum and measures the frame length, to catch a slot too short to hold 16 bits. Finally it checks the water-level thresholds on both sides of the boundary, and it checks that writing 0 to a write-1-to-clear flag does not clear it.

// File: rtl/i2s_audio_pkg.sv
package i2s_audio_pkg;
    typedef enum logic [1:0] {S_IDLE, S_LEFT, S_RIGHT} slot_e;

    localparam int unsigned LVL_W = 3;

    localparam logic [11:0] OFS_CTRL = 12'h000;
    localparam logic [11:0] OFS_STAT = 12'h004;
    localparam logic [11:0] OFS_ERR  = 12'h008;
    localparam logic [11:0] OFS_DIV  = 12'h00C;
    localparam logic [11:0] OFS_TXD  = 12'h010;
    localparam logic [11:0] OFS_RXD  = 12'h014;
    localparam logic [11:0] OFS_TCTL = 12'h300;
    localparam logic [11:0] OFS_TIN  = 12'h304;
    localparam logic [11:0] OFS_TOUT = 12'h308;
endpackage

// File: rtl/i2s_word_fifo.sv
module i2s_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push & ~full & ~flush;
    assign do_pop  = pop & ~empty & ~flush;
    assign rdata   = empty ? '0 : mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // R5: a full queue stays full when only a push arrives
    p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);
endmodule

// File: rtl/i2s_frame_engine.sv
module i2s_frame_engine
    import i2s_audio_pkg::*;
#(
    parameter int SW    = 16,
    parameter int DIV_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_tx,
    input  logic            run_rx,
    input  logic [DIV_W-1:0] div_val,
    input  logic            tx_empty,
    input  logic [2*SW-1:0] tx_word,
    output logic            tx_pop,
    output logic            tx_underrun,
    output logic            rx_push,
    output logic [2*SW-1:0] rx_word,
    input  logic            sdi,
    output logic            sck,
    output logic            ws,
    output logic            sdo
);
    localparam logic [DIV_W-1:0] MIN_SLOT = DIV_W'(SW + 1);
    localparam logic [DIV_W-1:0] LAST_BIT = DIV_W'(SW);

    slot_e            st, st_nx;
    logic [DIV_W-1:0] bitcnt, nb, lim;
    logic [SW-1:0]    osh, rhold;
    logic [2*SW-1:0]  rsh, new_word;
    logic             run, fall, rise, wrap, load_l;

    assign run      = run_tx | run_rx;
    assign lim      = (div_val < MIN_SLOT) ? MIN_SLOT : div_val;
    assign fall     = run & sck;
    assign rise     = run & ~sck;
    assign wrap     = fall & ((st == S_IDLE) | (bitcnt >= lim - DIV_W'(1)));
    assign nb       = wrap ? '0 : bitcnt + DIV_W'(1);
    assign load_l   = wrap & (st_nx == S_LEFT);
    assign tx_pop      = load_l & run_tx & ~tx_empty;
    assign tx_underrun = load_l & run_tx & tx_empty;
    assign rx_push  = wrap & (st == S_RIGHT) & run_rx;
    assign rx_word  = rsh;
    assign new_word = tx_pop ? tx_word : '0;

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (wrap) st_nx = S_LEFT;
            S_LEFT:  if (!run) st_nx = S_IDLE; else if (wrap) st_nx = S_RIGHT;
            S_RIGHT: if (!run) st_nx = S_IDLE; else if (wrap) st_nx = S_LEFT;
            default: st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck <= 1'b0; ws <= 1'b1; sdo <= 1'b0; bitcnt <= '0;
            osh <= '0; rhold <= '0; rsh <= '0;
        end else if (!run) begin
            sck <= 1'b0; ws <= 1'b1; sdo <= 1'b0; bitcnt <= '0;
        end else begin
            sck <= ~sck;
            if (fall) begin
                bitcnt <= nb;
                if (wrap) begin
                    ws  <= (st_nx == S_RIGHT);
                    sdo <= 1'b0;
                    if (st_nx == S_LEFT) begin
                        osh   <= new_word[2*SW-1:SW];
                        rhold <= new_word[SW-1:0];
                    end else begin
                        osh <= rhold;
                    end
                end else if (nb <= LAST_BIT) begin
                    sdo <= osh[SW-1];
                    osh <= osh << 1;
                end else begin
                    sdo <= 1'b0;
                end
            end
            if (rise && st != S_IDLE && bitcnt != '0 && bitcnt <= LAST_BIT)
                rsh <= {rsh[2*SW-2:0], sdi};
        end
    end

    // R3: word select moves only together with a falling bit clock or a stop
    p_ws_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ws != $past(ws)) |-> !sck);
    // R3: the first bit clock of every slot carries no data
    p_sdo_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bitcnt == '0) |-> !sdo);
endmodule

// File: rtl/i2s_apb_audio.sv
module i2s_apb_audio
    import i2s_audio_pkg::*;
#(
    parameter int          DEPTH   = 8,
    parameter int          SW      = 16,
    parameter int          DIV_W   = 10,
    parameter int unsigned LVL_RST = 2,
    parameter int unsigned DIV_RST = 128
) (
    input  logic        pclk,
    input  logic        presetn,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [11:0] paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    output logic        i2s_sck,
    output logic        i2s_ws,
    output logic        i2s_sdo,
    input  logic        i2s_sdi,
    output logic        irq,
    output logic        codec_reset
);
    localparam int CW   = $clog2(DEPTH) + 1;
    localparam int CMPW = (CW > int'(LVL_W)) ? CW : int'(LVL_W);

    logic             tx_en, tx_ie, rx_en, rx_ie, fifo_rst, codec_q, tmode;
    logic [LVL_W-1:0] tx_lvl, rx_lvl;
    logic [DIV_W-1:0] div_q;
    logic [1:0]       err_q;
    logic [3:0]       tout_q;

    logic wr, rd, wr_txd, wr_err, rx_ovr_evt, tx_ovr_evt;
    logic tx_full, tx_empty, rx_full, rx_empty, tx_alert, rx_alert, irq_int;
    logic [CW-1:0] tx_cnt, rx_cnt, tx_free, rx_free;
    logic [2*SW-1:0] tx_head, rx_head, rx_word;
    logic tx_pop, tx_udr, rx_push, e_sck, e_ws, e_sdo;

    assign wr     = psel & penable & pwrite;
    assign rd     = psel & penable & ~pwrite;
    assign wr_txd = wr & (paddr == OFS_TXD);
    assign wr_err = wr & (paddr == OFS_ERR);
    assign tx_ovr_evt = wr_txd & tx_full & ~fifo_rst;
    assign rx_ovr_evt = rx_push & rx_full & ~fifo_rst;

    i2s_word_fifo #(.W(2*SW), .DEPTH(DEPTH)) u_txq (
        .clk(pclk), .rst_n(presetn), .flush(fifo_rst), .push(wr_txd),
        .wdata(pwdata[2*SW-1:0]), .pop(tx_pop), .rdata(tx_head),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty));

    i2s_word_fifo #(.W(2*SW), .DEPTH(DEPTH)) u_rxq (
        .clk(pclk), .rst_n(presetn), .flush(fifo_rst), .push(rx_push),
        .wdata(rx_word), .pop(rd & (paddr == OFS_RXD)), .rdata(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty));

    i2s_frame_engine #(.SW(SW), .DIV_W(DIV_W)) u_eng (
        .clk(pclk), .rst_n(presetn), .run_tx(tx_en), .run_rx(rx_en),
        .div_val(div_q), .tx_empty(tx_empty), .tx_word(tx_head),
        .tx_pop(tx_pop), .tx_underrun(tx_udr), .rx_push(rx_push),
        .rx_word(rx_word), .sdi(i2s_sdi), .sck(e_sck), .ws(e_ws), .sdo(e_sdo));

    assign tx_free  = CW'(DEPTH) - tx_cnt;
    assign rx_free  = CW'(DEPTH) - rx_cnt;
    assign tx_alert = CMPW'(tx_free) > CMPW'(tx_lvl);
    assign rx_alert = CMPW'(rx_free) < CMPW'(rx_lvl);
    assign irq_int  = (tx_alert & tx_ie) | (rx_alert & rx_ie);

    assign i2s_sdo     = tmode ? tout_q[0] : e_sdo;
    assign i2s_sck     = tmode ? tout_q[1] : e_sck;
    assign i2s_ws      = tmode ? tout_q[2] : e_ws;
    assign irq         = tmode ? tout_q[3] : irq_int;
    assign codec_reset = codec_q;

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            {tx_en, tx_ie, rx_en, rx_ie, fifo_rst, codec_q, tmode} <= '0;
            tx_lvl <= LVL_W'(LVL_RST);
            rx_lvl <= LVL_W'(LVL_RST);
            div_q  <= DIV_W'(DIV_RST);
            err_q  <= '0;
            tout_q <= '0;
        end else begin
            if (wr && paddr == OFS_CTRL) begin
                tx_en <= pwdata[0]; tx_ie <= pwdata[1];
                rx_en <= pwdata[2]; rx_ie <= pwdata[3];
                tx_lvl <= pwdata[10:8]; rx_lvl <= pwdata[14:12];
                fifo_rst <= pwdata[16]; codec_q <= pwdata[17];
            end
            if (wr && paddr == OFS_DIV)  div_q  <= pwdata[DIV_W-1:0];
            if (wr && paddr == OFS_TCTL) tmode  <= pwdata[0];
            if (wr && paddr == OFS_TOUT) tout_q <= pwdata[3:0];
            err_q[0] <= (err_q[0] & ~(wr_err & pwdata[0])) | tx_ovr_evt | tx_udr;
            err_q[1] <= (err_q[1] & ~(wr_err & pwdata[1])) | rx_ovr_evt;
        end
    end

    always_comb begin
        case (paddr)
            OFS_CTRL: prdata = {14'b0, codec_q, fifo_rst, 1'b0, rx_lvl, 1'b0, tx_lvl,
                                4'b0, rx_ie, rx_en, tx_ie, tx_en};
            OFS_STAT: prdata = {26'b0, rx_full, rx_empty, tx_full, tx_empty, rx_alert, tx_alert};
            OFS_ERR:  prdata = {30'b0, err_q};
            OFS_DIV:  prdata = 32'(div_q);
            OFS_RXD:  prdata = 32'(rx_head);
            OFS_TCTL: prdata = {31'b0, tmode};
            OFS_TIN:  prdata = {31'b0, i2s_sdi};
            OFS_TOUT: prdata = {28'b0, tout_q};
            default:  prdata = '0;
        endcase
    end

    // R6: a dropped transmit write always leaves the error flag set
    p_txovr_flag_r6: assert property (@(posedge pclk) disable iff (!presetn)
        tx_ovr_evt |=> err_q[0]);
    // R6: a write of 1 clears the receive error when no new overrun arrives
    p_w1c_r6: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_err && pwdata[1] && !rx_ovr_evt) |=> !err_q[1]);
endmodule

// File: tb/i2s_apb_audio_tb.sv
module i2s_apb_audio_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0, prdata;
    logic sck, ws, sdo, sdi, irq, codec_reset;
    logic loop_en = 0, tb_sdi = 0;
    assign sdi = loop_en ? sdo : tb_sdi;

    i2s_apb_audio u_dut (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .i2s_sck(sck), .i2s_ws(ws), .i2s_sdo(sdo), .i2s_sdi(sdi),
        .irq(irq), .codec_reset(codec_reset));

    localparam logic [31:0] VEC [8] = '{
        32'h8001_7FFE, 32'h1234_ABCD, 32'hFFFF_0000, 32'h0000_FFFF,
        32'hA5A5_5A5A, 32'h0F0F_F0F0, 32'hC003_3FFC, 32'h7FFF_8000};

    int n_chk = 0, n_fail = 0;
    logic [31:0] rv;
    time t0, t1;

    // pin monitor: left samples seen on data out
    bit          mon_en = 0;
    logic        prev_ws = 1;
    int          pos = 0, nl = 0;
    logic [15:0] msh = '0;
    logic [15:0] lefts [16];
    always @(posedge sck) begin
        if (mon_en) begin
            if (ws != prev_ws) pos = 0; else pos = pos + 1;
            prev_ws = ws;
            if (pos >= 1 && pos <= 16) msh = {msh[14:0], sdo};
            if (pos == 16 && !ws && nl < 16) begin lefts[nl] = msh; nl = nl + 1; end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk); penable = 1; #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #1_900_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        apb_read(12'h000, rv); check("R1 ctrl", rv, 32'h0000_2200);
        apb_read(12'h00C, rv); check("R1 div", rv, 32'h80);
        apb_read(12'h004, rv); check("R1 status", rv, 32'h15);
        apb_read(12'h008, rv); check("R1 error", rv, 32'h0);
        check("R1 pins", {27'b0, sck, ws, sdo, irq, codec_reset}, 32'b01000);

        // R4 / R9 / R5 thresholds and flags
        for (int i = 0; i < 5; i++) apb_write(12'h010, VEC[i]);
        apb_read(12'h004, rv); check("R4 tx alert free 3", rv, 32'h11);
        apb_write(12'h000, 32'h2202);
        check("R9 irq tx alert", {31'b0, irq}, 32'h1);
        apb_write(12'h010, VEC[5]);
        apb_read(12'h004, rv); check("R4 no alert free 2", rv, 32'h10);
        check("R9 irq low", {31'b0, irq}, 32'h0);
        apb_write(12'h000, 32'h2200);
        for (int i = 6; i < 8; i++) apb_write(12'h010, VEC[i]);
        apb_read(12'h004, rv); check("R5 tx full", rv, 32'h18);

        // R6 overrun and write-1-to-clear
        apb_write(12'h010, 32'hDEAD_BEEF);
        apb_read(12'h008, rv); check("R6 tx overrun", rv, 32'h1);
        apb_write(12'h008, 32'h2);
        apb_read(12'h008, rv); check("R6 write 0 keeps", rv, 32'h1);
        apb_write(12'h008, 32'h1);
        apb_read(12'h008, rv); check("R6 write 1 clears", rv, 32'h0);

        // R2 / R3 / R7 loopback at divide 20
        apb_write(12'h00C, 32'd20);
        loop_en = 1; nl = 0; pos = 0; prev_ws = 1; mon_en = 1;
        apb_write(12'h000, 32'h2205);
        repeat (700) @(posedge clk);
        apb_write(12'h000, 32'h2200);
        mon_en = 0;
        apb_read(12'h004, rv); check("R5 rx full tx empty", rv, 32'h27);
        apb_read(12'h008, rv); check("R7 underrun flag", rv, 32'h1);
        apb_write(12'h000, 32'h2208);
        check("R9 irq rx alert", {31'b0, irq}, 32'h1);
        apb_write(12'h000, 32'h2200);
        for (int i = 0; i < 8; i++) begin
            apb_read(12'h014, rv); check("R2 loopback word", rv, VEC[i]);
        end
        check("R3 left count", 32'(nl), 32'd9);
        for (int i = 0; i < 8; i++) check("R3 left on pin", {16'b0, lefts[i]}, {16'b0, VEC[i][31:16]});
        check("R7 zeros sent", {16'b0, lefts[8]}, 32'h0);
        apb_read(12'h004, rv); check("R5 both empty", rv, 32'h15);
        apb_write(12'h008, 32'h1);

        // R13 frame length
        loop_en = 0; tb_sdi = 0;
        apb_write(12'h000, 32'h2204);
        @(negedge ws); t0 = $time; @(negedge ws); t1 = $time;
        check("R13 frame div 20", 32'((t1 - t0) / 10), 32'd80);
        apb_write(12'h000, 32'h2200);
        apb_write(12'h00C, 32'd5);
        apb_write(12'h000, 32'h2204);
        @(negedge ws); t0 = $time; @(negedge ws); t1 = $time;
        check("R13 frame min slot", 32'((t1 - t0) / 10), 32'd68);

        // R8 receive overrun
        repeat (800) @(posedge clk);
        apb_write(12'h000, 32'h2200);
        apb_read(12'h008, rv); check("R8 rx overrun", rv, 32'h2);
        apb_read(12'h004, rv); check("R8 rx still full", rv, 32'h27);
        apb_write(12'h008, 32'h2);

        // R10 queue reset
        apb_write(12'h010, VEC[1]); apb_write(12'h010, VEC[2]);
        apb_read(12'h004, rv); check("R10 before reset", rv, 32'h23);
        apb_write(12'h000, 32'h1_2200);
        apb_read(12'h000, rv); check("R10 ctrl readback", rv, 32'h0001_2200);
        apb_write(12'h010, VEC[3]);
        apb_read(12'h004, rv); check("R10 queues empty", rv, 32'h15);
        apb_write(12'h000, 32'h2200);

        // R11 codec reset pin
        apb_write(12'h000, 32'h2_2200);
        check("R11 codec high", {31'b0, codec_reset}, 32'h1);
        apb_write(12'h000, 32'h2200);
        check("R11 codec low", {31'b0, codec_reset}, 32'h0);

        // R12 test mode
        apb_write(12'h300, 32'h1);
        apb_write(12'h308, 32'hF);
        check("R12 pins all high", {28'b0, irq, ws, sck, sdo}, 32'hF);
        apb_write(12'h308, 32'h5);
        check("R12 pins pattern", {28'b0, irq, ws, sck, sdo}, 32'h5);
        tb_sdi = 1; apb_read(12'h304, rv); check("R12 sdi high", rv, 32'h1);
        tb_sdi = 0; apb_read(12'h304, rv); check("R12 sdi low", rv, 32'h0);
        apb_write(12'h300, 32'h0);
        check("R12 pins released", {28'b0, irq, ws, sck, sdo}, 32'h4);

        summary();
    end
endmodule